// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block produces two clamp (DC restore) pulses per video line, each timed in pixel clocks from the falling edge of a horizontal sync strobe. A line counter restarts on every detected sync falling edge and counts up to a ceiling, where it stays until the next edge arrives. Each pulse is high while the count lies in a window that begins at a shared start time and ends at that pulse's own end time. One pulse serves internal clamp logic. The other drives the gate input of an external converter.

The three 10-bit times are written one byte at a time through a small write port. Each time has a low-byte address and a high-byte address, and only the two low bits of the high byte are kept. Writes land in staging registers. The staged values are copied into the active window set only at a sync falling edge, so a line that is already running is never disturbed.

Top module: `clamp_pulse_gen`

## Requirements
- R1: A sync falling edge is detected at the rising clock edge E where `hsync` is sampled 0 and was sampled 1 at the edge before. At edge E the count restarts at 0 and then rises by one per clock. In the cycle after edge E+k, a pulse is high exactly when start <= k < end.
- R2: Each 10-bit time is the low byte with bits 1:0 of the high-byte write placed above it. Bits 7:2 of a high-byte write are ignored.
- R3: Write addresses are 0 for the start low byte, 1 for the start high byte, 2 for the internal end low byte, 3 for the internal end high byte, 4 for the external end low byte and 5 for the external end high byte. Writes to addresses 6 and 7 have no effect.
- R4: After reset the start time is 0 and both end times are 82 (0x052).
- R5: Both pulses share the start time, and each pulse has its own end time.
- R6: If a pulse's end time is less than or equal to the start time, that pulse stays low for the whole line.
- R7: Written values take effect at the next detected sync edge. A write in the middle of a line does not change that line. A write captured at the same edge as a detection takes effect only at the following detection.
- R8: With no further sync edge, the count stops at 1023. Both pulses are then low.
- R9: After reset, both pulses stay low until the first sync falling edge is detected.
- R10: A sync edge that arrives before the window has ended restarts the count. Timing of the new line follows R1 from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync strobe, synchronous to clk |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Byte register select |
| wr_data | input | 8 | Byte write data |
| clamp_int | output | 1 | Internal clamp pulse |
| clamp_ext | output | 1 | External clamp pulse for the converter gate |

## Verification
The bench drives `hsync` low on a falling clock edge, so detection happens at the next rising edge E. The outputs for count k are sampled at the falling edge that follows E+k, one clock after the edge for k = 0. Write data is captured at the rising edge after it is driven, but the window only changes at a later detection. The bench therefore keeps its own staging and active copies of the three times and copies staging to active at each edge it generates. Every line is checked on every cycle against a window computed arithmetically from the active copy, with the count capped at 1023.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  // Number of programmable times: shared start, internal end, external end
  localparam int unsigned NUM_TIMES = 3;
  localparam int unsigned IDX_START = 0;
  localparam int unsigned IDX_IEND  = 1;
  localparam int unsigned IDX_EEND  = 2;

  // Reset values of the times, in clocks
  function automatic int unsigned reset_time(input int unsigned idx);
    return (idx == IDX_START) ? 0 : 82;
  endfunction

  // Byte address of one half of a time: low byte even, high byte odd
  function automatic logic [2:0] byte_addr(input int unsigned idx, input logic hi);
    return 3'(2 * idx) | {2'b00, hi};
  endfunction
endpackage

// File: rtl/clamp_line_counter.sv
module clamp_line_counter #(
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  output logic          sync_fall,
  output logic          armed,
  output logic [TW-1:0] count
);
  localparam logic [TW-1:0] CMAX = {TW{1'b1}};

  logic hs_q;

  assign sync_fall = hs_q & ~hsync;

  function automatic logic [TW-1:0] next_count(input logic [TW-1:0] c, input logic restart);
    if (restart)        return '0;
    else if (c == CMAX) return CMAX;
    else                return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      armed <= 1'b0;
      count <= CMAX;
    end else begin
      hs_q  <= hsync;
      count <= next_count(count, sync_fall);
      if (sync_fall) armed <= 1'b1;
    end
  end

  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> (count == '0) && armed);
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX) && !sync_fall |=> count == CMAX);
endmodule

// File: rtl/clamp_time_regs.sv
module clamp_time_regs
  import clamp_pkg::*;
#(
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          load,
  output logic [TW-1:0] act_start,
  output logic [TW-1:0] act_iend,
  output logic [TW-1:0] act_eend
);
  localparam int unsigned HW = TW - 8;

  logic [TW-1:0] active [NUM_TIMES];

  for (genvar i = 0; i < NUM_TIMES; i++) begin : g_time
    localparam logic [TW-1:0] RST = TW'(reset_time(i));
    logic [7:0]    lo_q;
    logic [HW-1:0] hi_q;
    logic          wr_lo, wr_hi;

    assign wr_lo = wr_en && (wr_addr == byte_addr(i, 1'b0));
    assign wr_hi = wr_en && (wr_addr == byte_addr(i, 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q      <= RST[7:0];
        hi_q      <= RST[TW-1:8];
        active[i] <= RST;
      end else begin
        if (wr_lo) lo_q <= wr_data;
        if (wr_hi) hi_q <= wr_data[HW-1:0];
        if (load)  active[i] <= {hi_q, lo_q};
      end
    end
  end

  assign act_start = active[IDX_START];
  assign act_iend  = active[IDX_IEND];
  assign act_eend  = active[IDX_EEND];

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_start) && $stable(act_iend) && $stable(act_eend));
endmodule

// File: rtl/clamp_window.sv
module clamp_window #(
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic [TW-1:0] count,
  input  logic [TW-1:0] t_start,
  input  logic [TW-1:0] t_end,
  output logic          pulse
);
  function automatic logic in_window(input logic [TW-1:0] c,
                                     input logic [TW-1:0] s,
                                     input logic [TW-1:0] e);
    return (c >= s) && (c < e);
  endfunction

  assign pulse = armed && in_window(count, t_start, t_end);

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_end <= t_start) |-> !pulse);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pulse);
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int unsigned TW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       clamp_int,
  output logic       clamp_ext
);
  localparam int unsigned NCH = 2;

  logic          sync_fall;
  logic          armed;
  logic [TW-1:0] count;
  logic [TW-1:0] act_start, act_iend, act_eend;
  logic [TW-1:0] ch_end [NCH];
  logic [NCH-1:0] ch_pulse;

  clamp_line_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .sync_fall(sync_fall), .armed(armed), .count(count)
  );

  clamp_time_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(sync_fall),
    .act_start(act_start), .act_iend(act_iend), .act_eend(act_eend)
  );

  assign ch_end[0] = act_iend;
  assign ch_end[1] = act_eend;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    clamp_window #(.TW(TW)) u_win (
      .clk(clk), .rst_n(rst_n), .armed(armed), .count(count),
      .t_start(act_start), .t_end(ch_end[c]), .pulse(ch_pulse[c])
    );
  end

  assign clamp_int = ch_pulse[0];
  assign clamp_ext = ch_pulse[1];

  assert_shared_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count < act_start) |-> !(clamp_int || clamp_ext));
endmodule

// File: tb/clamp_pulse_gen_test.sv
module clamp_pulse_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic clamp_int, clamp_ext;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [9:0] st [3];
  logic [9:0] act [3];

  always #5 clk = ~clk;

  clamp_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .clamp_int(clamp_int), .clamp_ext(clamp_ext)
  );

  function automatic bit expect_win(input int k, input int s, input int e);
    int kc = (k > 1023) ? 1023 : k;
    return (kc >= s) && (kc < e);
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (a < 3'd6) begin
      if (a[0]) st[a >> 1][9:8] = d[1:0];
      else      st[a >> 1][7:0] = d;
    end
  endtask

  task automatic chk(input bit got, input bit exp, input string tag, input int k);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%0b expected=%0b", tag, k, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_time(input int idx, input logic [9:0] v, input logic [5:0] junk);
    reg_write(3'(2 * idx), v[7:0]);
    reg_write(3'(2 * idx + 1), {junk, v[9:8]});
  endtask

  // One line of n cycles; optional write at count mid_k, optional write on the detecting edge
  task automatic run_line(input int n, input int mid_k, input logic [2:0] ma, input logic [7:0] md,
                          input bit same_wr, input logic [2:0] sa, input logic [7:0] sd,
                          input string tag);
    hsync = 1'b0;
    if (same_wr) begin wr_en = 1'b1; wr_addr = sa; wr_data = sd; end
    @(posedge clk);
    for (int i = 0; i < 3; i++) act[i] = st[i];
    if (same_wr) model_write(sa, sd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin hsync = 1'b1; wr_en = 1'b0; end
      if (k == mid_k + 1) wr_en = 1'b0;
      chk(clamp_int, expect_win(k, act[0], act[1]), {tag, " int"}, k);
      chk(clamp_ext, expect_win(k, act[0], act[2]), {tag, " ext"}, k);
      if (k == mid_k) begin
        wr_en = 1'b1; wr_addr = ma; wr_data = md;
        model_write(ma, md);
      end
    end
  endtask

  task automatic plain_line(input int n, input string tag);
    run_line(n, -5, 3'd0, 8'd0, 1'b0, 3'd0, 8'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    st[0] = 10'd0; st[1] = 10'd82; st[2] = 10'd82;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: no pulse before the first sync edge
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(clamp_int, 1'b0, "R9 idle int", i);
      chk(clamp_ext, 1'b0, "R9 idle ext", i);
    end
    // R4: reset times give a pulse over counts 0..81
    plain_line(90, "R4 R1 reset times");
    // R2: high-byte upper bits ignored; R5: separate ends
    set_time(0, 10'h102, 6'h3F);
    set_time(1, 10'h110, 6'h00);
    set_time(2, 10'h220, 6'h2A);
    plain_line(560, "R2 R5 split bytes");
    // R3: addresses 6 and 7 do nothing
    reg_write(3'd6, 8'hFF);
    reg_write(3'd7, 8'h00);
    plain_line(560, "R3 unused addr");
    // R7: a write mid-line leaves the line alone, then applies at the next edge
    run_line(560, 100, 3'd0, 8'h00, 1'b0, 3'd0, 8'd0, "R7 mid write");
    plain_line(560, "R7 applied");
    // R7: a write on the detecting edge waits for the following edge
    run_line(560, -5, 3'd0, 8'd0, 1'b1, 3'd2, 8'h80, "R7 same edge");
    plain_line(600, "R7 same edge applied");
    // R10: retrigger before the window ends
    plain_line(300, "R10 short line");
    plain_line(600, "R10 restarted");
    // R1 R6 R5: sweep of start and end times
    foreach (st[i]) st[i] = st[i];
    for (int si = 0; si < 4; si++) begin
      for (int ei = 0; ei < 6; ei++) begin
        int sv, ev, e2, n;
        sv = (si == 0) ? 0 : (si == 1) ? 3 : (si == 2) ? 82 : 500;
        ev = (ei == 0) ? 0 : (ei == 1) ? 1 : (ei == 2) ? 4 : (ei == 3) ? 83 : (ei == 4) ? 600 : 1023;
        e2 = (ev + 7) % 1024;
        set_time(0, 10'(sv), 6'h15);
        set_time(1, 10'(ev), 6'h00);
        set_time(2, 10'(e2), 6'h3C);
        n = ((ev > e2) ? ev : e2) + 3;
        if (n > 1030) n = 1030;
        plain_line(n, "R1 R6 R5 sweep");
      end
    end
    // R8: counter saturates at 1023, pulses end
    set_time(0, 10'd1000, 6'h00);
    set_time(1, 10'd1023, 6'h00);
    set_time(2, 10'd1010, 6'h00);
    plain_line(1100, "R8 saturate");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule